// File: doc/BRIEF.md
# Byte-Wide Configuration Port with Abort Handling

This block is the slave end of a parallel configuration port. It has an active-low select, a direction input and a data bus. The data bus is split into an input half, an output half and an output enable. Every rising edge of the configuration clock moves one word while the port is selected. With the direction input at 0, the word on `din` is captured and handed on through `wr_data`/`wr_valid`. With the direction input at 1, the port pulls one word from `rd_word`, presents it on `dout` and raises `doe`.

An abort is a change of the direction input while a transfer is under way and the port stays selected. From then on the port reports `busy` until the select is released, and it ignores all further data.

The two kinds of abort are handled differently:
- **Abort of a write.** The bus has just been turned towards the host. The port drives a status byte, captured from `status_in` at the moment of detection, on the low eight data lines, and drives all higher lines to 1.
- **Abort of a readback.** The direction now points into the port, so nothing is driven.

When the select is released, the port returns to idle. A new transfer starts only on a fresh select.

Top module: `cfgport_abort_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `busy`, `doe`, `wr_valid` and `rd_take` are all 0.
- R2: At an edge with `sel_n`=0 and `dir_read`=0, in idle or normal write, `wr_valid`=1 in the next cycle and `wr_data` equals the `din` sampled at that edge.
- R3: At an edge with `sel_n`=0 and `dir_read`=1, in idle or normal readback, `rd_take`=1, `doe`=1 and `dout` equals the sampled `rd_word` in the next cycle.
- R4: At an edge during a normal transfer where `sel_n`=0 and `dir_read` differs from its value at the previous edge, `busy` is 1 in the next cycle.
- R5: Once `busy` is 1, it stays 1 while `sel_n` is sampled 0, whatever `dir_read` does.
- R6: An edge with `sel_n`=1 ends any abort or transfer: `busy`, `doe`, `wr_valid` and `rd_take` are 0 in the next cycle.
- R7: During an abort of a write, `doe`=1. `dout[7:0]` carries the status byte in the same bit order (`status_in[0]` on `dout[0]`), and all bits above 7 are 1.
- R8: The status byte shown is the value of `status_in` at the detection edge. It stays unchanged for the rest of the abort even when `status_in` changes.
- R9: During an abort of a readback, `doe` stays 0 for the whole abort.
- R10: `doe` is 0 in a normal write cycle and in idle.
- R11: No word is captured or pulled at the detection edge or during an abort: `wr_valid` and `rd_take` stay 0 while `busy` is 1.
- R12: A change of `dir_read` while `sel_n`=1 is not an abort. The next select starts a normal transfer in the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low port select |
| dir_read | input | 1 | Transfer direction: 1 readback, 0 write |
| din | input | DATA_W | Data bus, input half |
| dout | output | DATA_W | Data bus, output half |
| doe | output | 1 | Output enable for `dout` |
| busy | output | 1 | High for the length of an abort |
| status_in | input | 8 | Status byte source for write aborts |
| wr_valid | output | 1 | Pulse: a write word was captured |
| wr_data | output | DATA_W | Captured write word |
| rd_word | input | DATA_W | Next readback word |
| rd_take | output | 1 | Pulse: a readback word was pulled |

## Verification
At a single edge, a transfer can meet both an abort and the capture of a status byte. The direction flip that would move the next word instead starts the abort, and `status_in` changes at the same time. The bench provokes this by flipping `dir_read` in the middle of write and readback bursts. On the following cycle it expects no `wr_valid` or `rd_take`, `busy` raised and, for a write abort, exactly the status value present at that edge. A release of `sel_n` that comes together with a direction change is also driven, and it must end in idle rather than a new abort.

// File: rtl/cfgp_pkg.sv
// Package: shared state encoding and widths for the configuration port.
package cfgp_pkg;
    localparam int STATUS_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WRITE    = 3'd1,
        ST_READ     = 3'd2,
        ST_ABORT_WR = 3'd3,
        ST_ABORT_RD = 3'd4
    } cfgp_state_e;
endpackage

// File: rtl/cfgp_ctrl_fsm.sv
// Control state machine of the configuration port.
// Decides, per clock edge, whether a word is written, a word is read,
// or an abort begins. Assumes sel_n and dir_read are already synchronous
// to clk. The direction seen at the previous edge is kept for detection.
module cfgp_ctrl_fsm
    import cfgp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_n,
    input  logic        dir_read,
    output cfgp_state_e state,
    output logic        abort_hit,
    output logic        wr_take,
    output logic        rd_pull
);
    cfgp_state_e st_q, st_d;
    logic        dir_q;

    // Next-state and per-edge action decode.
    always_comb begin
        st_d      = st_q;
        abort_hit = 1'b0;
        wr_take   = 1'b0;
        rd_pull   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (!sel_n) begin
                    if (dir_read) begin
                        st_d    = ST_READ;
                        rd_pull = 1'b1;
                    end else begin
                        st_d    = ST_WRITE;
                        wr_take = 1'b1;
                    end
                end
            end
            ST_WRITE, ST_READ: begin
                if (sel_n) begin
                    st_d = ST_IDLE;
                end else if (dir_read != dir_q) begin
                    abort_hit = 1'b1;
                    st_d      = (st_q == ST_WRITE) ? ST_ABORT_WR : ST_ABORT_RD;
                end else if (dir_read) begin
                    rd_pull = 1'b1;
                end else begin
                    wr_take = 1'b1;
                end
            end
            ST_ABORT_WR, ST_ABORT_RD: begin
                if (sel_n) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State and last-direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            dir_q <= 1'b1;
        end else begin
            st_q  <= st_d;
            dir_q <= dir_read;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/cfgp_status_cap.sv
// Status capture: samples the status byte at the edge that detects an abort
// and holds it until the next detection. Assumes status_in is synchronous.
module cfgp_status_cap
    import cfgp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic [STATUS_W-1:0] status_in,
    output logic [STATUS_W-1:0] status_q
);
    // Hold register for the abort status byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= '0;
        else if (capture) status_q <= status_in;
    end
endmodule

// File: rtl/cfgp_datapath.sv
// Data path of the configuration port: write capture, readback register and
// the output mux that puts either readback data or the padded status byte
// on the bus. Assumes DATA_W >= 8.
module cfgp_datapath
    import cfgp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cfgp_state_e         state,
    input  logic                wr_take,
    input  logic                rd_pull,
    input  logic [DATA_W-1:0]   din,
    input  logic [DATA_W-1:0]   rd_word,
    input  logic [STATUS_W-1:0] status_q,
    output logic                wr_valid,
    output logic [DATA_W-1:0]   wr_data,
    output logic                rd_take,
    output logic [DATA_W-1:0]   dout,
    output logic                doe
);
    localparam int PAD_W = DATA_W - STATUS_W;

    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] status_bus;

    // Write word capture and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_valid <= wr_take;
            if (wr_take) wr_data <= din;
        end
    end

    // Readback word register and pull pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_take <= 1'b0;
            rd_q    <= '0;
        end else begin
            rd_take <= rd_pull;
            if (rd_pull) rd_q <= rd_word;
        end
    end

    // Status word: low byte as captured, upper lines held high.
    generate
        if (PAD_W > 0) begin : g_pad
            assign status_bus = {{PAD_W{1'b1}}, status_q};
        end else begin : g_nopad
            assign status_bus = status_q;
        end
    endgenerate

    // Output mux and enable.
    always_comb begin
        doe  = (state == ST_READ) || (state == ST_ABORT_WR);
        dout = (state == ST_ABORT_WR) ? status_bus : rd_q;
    end
endmodule

// File: rtl/cfgport_abort_ctrl.sv
// Top of the byte-wide configuration port with abort handling.
// One word per clock while selected; an abort is a direction change during
// a transfer with the select held low. Assumes all inputs are synchronous
// to clk and that the bus pads are built outside from dout/doe/din.
module cfgport_abort_ctrl
    import cfgp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_n,
    input  logic                dir_read,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   dout,
    output logic                doe,
    output logic                busy,
    input  logic [STATUS_W-1:0] status_in,
    output logic                wr_valid,
    output logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W-1:0]   rd_word,
    output logic                rd_take
);
    cfgp_state_e         state;
    logic                abort_hit;
    logic                wr_take;
    logic                rd_pull;
    logic [STATUS_W-1:0] status_q;

    cfgp_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .dir_read  (dir_read),
        .state     (state),
        .abort_hit (abort_hit),
        .wr_take   (wr_take),
        .rd_pull   (rd_pull)
    );

    cfgp_status_cap u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (abort_hit),
        .status_in (status_in),
        .status_q  (status_q)
    );

    cfgp_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .wr_take  (wr_take),
        .rd_pull  (rd_pull),
        .din      (din),
        .rd_word  (rd_word),
        .status_q (status_q),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .rd_take  (rd_take),
        .dout     (dout),
        .doe      (doe)
    );

    // Busy flag follows the abort states.
    always_comb busy = (state == ST_ABORT_WR) || (state == ST_ABORT_RD);
endmodule

// File: rtl/cfgp_abort_chk.sv
// Checker for the configuration port: port-level temporal properties.
module cfgp_abort_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              dir_read,
    input logic [DATA_W-1:0] dout,
    input logic              doe,
    input logic              busy,
    input logic              wr_valid,
    input logic              rd_take
);
    localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'(8'hFF);

    assert_abort_detect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!sel_n) && !sel_n && !busy && (dir_read != $past(dir_read))) |=> busy);

    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sel_n) |=> busy);

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (!busy && !doe && !wr_valid && !rd_take));

    assert_status_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && doe) |-> ((dout | LOW_MASK) == {DATA_W{1'b1}}));

    assert_status_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && doe && $past(busy) && $past(rst_n)) |-> $stable(dout));

    assert_write_no_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!sel_n) && !$past(dir_read) && !busy) |-> !doe);

    assert_no_move_in_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!wr_valid && !rd_take));
endmodule

bind cfgport_abort_ctrl cfgp_abort_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .dir_read (dir_read),
    .dout     (dout),
    .doe      (doe),
    .busy     (busy),
    .wr_valid (wr_valid),
    .rd_take  (rd_take)
);

// File: tb/cfgport_abort_ctrl_tb.sv
// Scoreboard bench: the driver applies one cycle of stimulus, predicts the
// outputs after the next edge and queues them; the monitor compares.
module cfgport_abort_ctrl_tb;
    localparam int DW = 16;

    typedef struct {
        logic          busy;
        logic          doe;
        logic          wv;
        logic          rt;
        logic [DW-1:0] dout;
        logic [DW-1:0] wd;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          dir_read = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] rd_word = '0;
    logic [7:0]    status_in = '0;
    logic [DW-1:0] dout;
    logic          doe, busy, wr_valid, rd_take;
    logic [DW-1:0] wr_data;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    // Prediction model state: 0 idle, 1 write, 2 read, 3 write abort, 4 read abort
    int         m_mode = 0;
    logic       m_dir = 1'b1;
    logic [7:0] m_stat = '0;
    logic [DW-1:0] m_rdq = '0;

    always #4 clk = ~clk;

    cfgport_abort_ctrl #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .dir_read(dir_read),
        .din(din), .dout(dout), .doe(doe), .busy(busy), .status_in(status_in),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_word(rd_word), .rd_take(rd_take)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // One clock of stimulus plus the predicted outputs after the edge.
    task automatic cyc(input logic s, input logic d, input logic [DW-1:0] dn,
                       input logic [7:0] st, input logic [DW-1:0] rw, input string tag);
        exp_t e;
        @(negedge clk);
        sel_n = s; dir_read = d; din = dn; status_in = st; rd_word = rw;
        e.wv = 1'b0; e.rt = 1'b0; e.wd = '0; e.tag = tag;
        case (m_mode)
            0: if (!s) begin
                   if (d) begin m_mode = 2; e.rt = 1'b1; m_rdq = rw; end
                   else   begin m_mode = 1; e.wv = 1'b1; e.wd = dn; end
               end
            1, 2: if (s) m_mode = 0;
                  else if (d != m_dir) begin m_mode = (m_mode == 1) ? 3 : 4; m_stat = st; end
                  else if (d) begin e.rt = 1'b1; m_rdq = rw; end
                  else begin e.wv = 1'b1; e.wd = dn; end
            default: if (s) m_mode = 0;
        endcase
        m_dir  = d;
        e.busy = (m_mode == 3) || (m_mode == 4);
        e.doe  = (m_mode == 2) || (m_mode == 3);
        e.dout = (m_mode == 3) ? {8'hFF, m_stat} : m_rdq;
        q.push_back(e);
    endtask

    // Monitor: compare queued predictions just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                logic bad;
                e = q.pop_front();
                n_chk++;
                bad = (busy !== e.busy) || (doe !== e.doe) || (wr_valid !== e.wv) ||
                      (rd_take !== e.rt) || (e.doe && (dout !== e.dout)) ||
                      (e.wv && (wr_data !== e.wd));
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s: busy/doe/wv/rt/dout/wd act=%b%b%b%b %h %h exp=%b%b%b%b %h %h",
                             e.tag, busy, doe, wr_valid, rd_take, dout, wr_data,
                             e.busy, e.doe, e.wv, e.rt, e.dout, e.wd);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: act=running exp=finished");
            summary();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        n_chk++;
        if (busy || doe || wr_valid || rd_take) begin
            n_fail++;
            $display("FAIL R1: busy/doe/wv/rt act=%b%b%b%b exp=0000", busy, doe, wr_valid, rd_take);
        end
        @(negedge clk); rst_n = 1'b1;

        // R2, R10: write burst with doe low
        cyc(0, 0, 16'h1111, 8'h00, 16'h0, "R2");
        cyc(0, 0, 16'h2222, 8'h00, 16'h0, "R10");
        cyc(0, 0, 16'hABCD, 8'h00, 16'h0, "R2");
        cyc(1, 0, 16'h0000, 8'h00, 16'h0, "R6");
        cyc(1, 1, 16'h0000, 8'h00, 16'h0, "R10");

        // R3: readback burst
        cyc(0, 1, 16'h0, 8'h00, 16'h5A5A, "R3");
        cyc(0, 1, 16'h0, 8'h00, 16'hC3C3, "R3");
        cyc(0, 1, 16'h0, 8'h00, 16'h0F0F, "R3");
        cyc(1, 1, 16'h0, 8'h00, 16'h0000, "R6");

        // R4, R7, R8, R5, R11: write abort, status changes and dir toggles
        cyc(0, 0, 16'h7777, 8'h00, 16'h0, "R2");
        cyc(0, 1, 16'h8888, 8'hA5, 16'h0, "R4");
        cyc(0, 1, 16'h9999, 8'h3C, 16'h0, "R8");
        cyc(0, 0, 16'h9999, 8'hFF, 16'h0, "R5");
        cyc(0, 1, 16'h4444, 8'h00, 16'h0, "R11");
        cyc(1, 1, 16'h0, 8'h00, 16'h0, "R6");

        // R7: status bit order, abort after a single word
        cyc(0, 0, 16'h0001, 8'h00, 16'h0, "R2");
        cyc(0, 1, 16'h0, 8'h01, 16'h0, "R7");
        cyc(0, 1, 16'h0, 8'h80, 16'h0, "R7");
        cyc(1, 0, 16'h0, 8'h00, 16'h0, "R6");

        // R9, R11: readback abort
        cyc(0, 1, 16'h0, 8'h00, 16'h1234, "R3");
        cyc(0, 1, 16'h0, 8'h00, 16'h5678, "R3");
        cyc(0, 0, 16'hDEAD, 8'h55, 16'h9ABC, "R9");
        cyc(0, 0, 16'hBEEF, 8'h66, 16'h9ABC, "R11");
        cyc(0, 1, 16'hBEEF, 8'h66, 16'h9ABC, "R9");
        cyc(1, 1, 16'h0, 8'h00, 16'h0, "R6");

        // R12: direction flips while deselected, then new transfers
        cyc(0, 0, 16'h3333, 8'h00, 16'h0, "R2");
        cyc(1, 1, 16'h0, 8'h00, 16'h0, "R12");
        cyc(1, 0, 16'h0, 8'h00, 16'h0, "R12");
        cyc(1, 1, 16'h0, 8'h00, 16'h0, "R12");
        cyc(0, 1, 16'h0, 8'h00, 16'h6666, "R12");
        cyc(0, 1, 16'h0, 8'h00, 16'h6767, "R3");
        cyc(1, 0, 16'h0, 8'h00, 16'h0, "R12");
        cyc(0, 0, 16'hCAFE, 8'h00, 16'h0, "R12");
        cyc(1, 0, 16'h0, 8'h00, 16'h0, "R6");

        repeat (3) @(posedge clk);
        #3;
        n_chk++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R6: pending act=%0d exp=0", q.size());
        end
        done = 1'b1;
        summary();
    end
endmodule